// File: doc/BRIEF.md
# Status Flags and Branch Condition Unit

This block keeps the processor status word: a 16-bit register whose condition bits follow the results of the arithmetic unit and whose control bits change only on command. Each cycle the datapath presents a result together with its carry-out, auxiliary (nibble) carry, overflow and operation width. A per-flag enable mask selects which condition bits take the new values. The other condition bits keep their old values.

The same block answers conditional-branch questions. A five-bit condition code picks one predicate: a signed or unsigned comparison, a single flag, or a test of whether the loop counter is zero. The predicate is evaluated against the flags register as it stands and is returned at once on `take_o`. Software can also replace the whole word in one load, for example on a context restore. The positions that carry no flag always read as a fixed pattern.

Top module: `psw_cond_unit`

## Requirements
- R1: Flag positions in `flags_o` are: carry 0, parity 2, auxiliary 4, zero 6, sign 7, single-step 8, interrupt-enable 9, direction 10, overflow 11. After reset every defined flag is 0 and `flags_o` equals 16'hF002.
- R2: Bits 1, 3, 5 and 12 to 15 are reserved. They always read as the matching bits of the parameter `RSVD_VAL` (default 16'hF002: bit 1 and bits 12..15 set, bits 3 and 5 clear), whatever is loaded or updated.
- R3: When its enable is set, carry takes `carry_i`, auxiliary takes `aux_i` and overflow takes `ovf_i` at the next clock edge.
- R4: With `wide_i`=0 (byte), zero is set when `res_i[7:0]` is 0 and sign copies `res_i[7]`. With `wide_i`=1 (word), zero is set when `res_i[15:0]` is 0 and sign copies `res_i[15]`.
- R5: Parity is set when `res_i[7:0]` holds an even number of ones, for both widths.
- R6: `upd_en_i` bit 0 enables carry, bit 1 parity, bit 2 auxiliary, bit 3 zero, bit 4 sign and bit 5 overflow. A condition flag whose enable is 0 keeps its value.
- R7: `ctl_set_i`/`ctl_clr_i` bit 0 addresses single-step, bit 1 interrupt-enable and bit 2 direction. A set bit forces the flag to 1 and a clear bit forces it to 0. Set wins when both are given. Without a command or a load these flags never change.
- R8: `load_i` writes `load_val_i` to all defined flags at the next edge. A load overrides any update or control command given in the same cycle.
- R9: Signed codes: 12 less (sign xor overflow), 13 greater-or-equal (its complement), 14 less-or-equal ((sign xor overflow) or zero), 15 greater (its complement).
- R10: Unsigned codes: 2 below (carry), 3 above-or-equal (not carry), 6 below-or-equal (carry or zero), 7 above (neither).
- R11: Single-flag codes: 0 overflow, 1 not overflow, 4 zero, 5 not zero, 8 sign, 9 not sign, 10 parity, 11 not parity.
- R12: Code 16 is taken exactly when `cnt_zero_i` is 1. Codes 17 to 31 are never taken.
- R13: `take_o` is combinational. It reflects the current `flags_o`, `cond_i` and `cnt_zero_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| res_i | input | 16 | Arithmetic result |
| carry_i | input | 1 | Carry out of the result's top bit |
| aux_i | input | 1 | Carry out of bit 3 |
| ovf_i | input | 1 | Signed overflow of the operation |
| wide_i | input | 1 | 1 = word operation, 0 = byte operation |
| upd_en_i | input | 6 | Per-condition-flag update enables |
| ctl_set_i | input | 3 | Set commands for the control flags |
| ctl_clr_i | input | 3 | Clear commands for the control flags |
| load_i | input | 1 | Load the whole flags word |
| load_val_i | input | 16 | Value for a load |
| cond_i | input | 5 | Branch condition code |
| cnt_zero_i | input | 1 | Loop counter equals zero |
| flags_o | output | 16 | Flags register |
| take_o | output | 1 | Branch predicate result |

## Verification
The assertions check several properties on every cycle: the reserved pattern, that a load fully decides the next word, that control flags and masked condition flags hold without a command, the carry and width-dependent sign capture, and the fixed answers of codes 16 to 31. Parity over the low byte, the zero test at each width, set-over-clear priority and the full predicate table under mixed flag states can only be shown by the bench's scenarios. The bench compares every cycle against its own model of the register and of all seventeen predicates.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int FLAGS_W  = 16;
    localparam int BYTE_W   = 8;
    localparam int N_UPD    = 6;
    localparam int N_CTL    = 3;
    localparam int COND_W   = 5;

    // Bit positions inside the flags word (neighbouring logic decodes them)
    localparam int POS_CARRY = 0;
    localparam int POS_PAR   = 2;
    localparam int POS_AUX   = 4;
    localparam int POS_ZERO  = 6;
    localparam int POS_SIGN  = 7;
    localparam int POS_STEP  = 8;
    localparam int POS_IRQ   = 9;
    localparam int POS_DIR   = 10;
    localparam int POS_OVF   = 11;

    localparam logic [FLAGS_W-1:0] DEF_MASK  = 16'h0FD5;
    localparam logic [FLAGS_W-1:0] COND_MASK = 16'h08D5;
    localparam logic [FLAGS_W-1:0] CTL_MASK  = 16'h0700;

    // Predicate bases: code = {base, invert} for bases 0..7
    localparam logic [3:0] BASE_OVF  = 4'd0;
    localparam logic [3:0] BASE_CY   = 4'd1;
    localparam logic [3:0] BASE_ZR   = 4'd2;
    localparam logic [3:0] BASE_CYZR = 4'd3;
    localparam logic [3:0] BASE_SGN  = 4'd4;
    localparam logic [3:0] BASE_PAR  = 4'd5;
    localparam logic [3:0] BASE_LT   = 4'd6;
    localparam logic [3:0] BASE_LE   = 4'd7;
    localparam logic [COND_W-1:0] CC_CNT_ZERO = 5'd16;

    typedef struct packed {
        logic [FLAGS_W-1:0] flags;
    } psw_state_t;

    function automatic int upd_pos(input int idx);
        case (idx)
            0:       upd_pos = POS_CARRY;
            1:       upd_pos = POS_PAR;
            2:       upd_pos = POS_AUX;
            3:       upd_pos = POS_ZERO;
            4:       upd_pos = POS_SIGN;
            default: upd_pos = POS_OVF;
        endcase
    endfunction

    function automatic int ctl_pos(input int idx);
        case (idx)
            0:       ctl_pos = POS_STEP;
            1:       ctl_pos = POS_IRQ;
            default: ctl_pos = POS_DIR;
        endcase
    endfunction

endpackage

// File: rtl/psw_result_eval.sv
module psw_result_eval
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              wide_i,
    output logic              zero_o,
    output logic              sign_o,
    output logic              par_o
);
    localparam int LO_W = BYTE_W;

    logic [LO_W-1:0] lo_byte;
    logic            lo_zero;
    logic            hi_zero;
    logic [LO_W:0]   par_chain;

    assign lo_byte = res_i[LO_W-1:0];
    assign lo_zero = (lo_byte == '0);
    assign hi_zero = (res_i[DATA_W-1:LO_W] == '0);

    // Parity chain over the low byte
    assign par_chain[0] = 1'b0;
    for (genvar g = 0; g < LO_W; g++) begin : g_par
        assign par_chain[g+1] = par_chain[g] ^ lo_byte[g];
    end

    always_comb begin
        par_o = ~par_chain[LO_W];
        if (wide_i) begin
            zero_o = lo_zero & hi_zero;
            sign_o = res_i[DATA_W-1];
        end else begin
            zero_o = lo_zero;
            sign_o = res_i[LO_W-1];
        end
    end

endmodule

// File: rtl/psw_ctl_next.sv
module psw_ctl_next
    import psw_pkg::*;
#(
    parameter int NUM = N_CTL
) (
    input  logic [NUM-1:0] cur_i,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] nxt_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_ctl
        always_comb begin
            if (set_i[g]) begin
                nxt_o[g] = 1'b1;
            end else if (clr_i[g]) begin
                nxt_o[g] = 1'b0;
            end else begin
                nxt_o[g] = cur_i[g];
            end
        end
    end

endmodule

// File: rtl/psw_branch_eval.sv
module psw_branch_eval
    import psw_pkg::*;
(
    input  logic [FLAGS_W-1:0] flags_i,
    input  logic [COND_W-1:0]  cond_i,
    input  logic               cnt_zero_i,
    output logic               take_o
);
    logic       cy, zr, sg, pr, ov;
    logic       raw;
    logic [3:0] base;
    logic       inv;

    assign cy   = flags_i[POS_CARRY];
    assign zr   = flags_i[POS_ZERO];
    assign sg   = flags_i[POS_SIGN];
    assign pr   = flags_i[POS_PAR];
    assign ov   = flags_i[POS_OVF];
    assign base = cond_i[COND_W-1:1];
    assign inv  = cond_i[0];

    always_comb begin
        case (base)
            BASE_OVF:  raw = ov;
            BASE_CY:   raw = cy;
            BASE_ZR:   raw = zr;
            BASE_CYZR: raw = cy | zr;
            BASE_SGN:  raw = sg;
            BASE_PAR:  raw = pr;
            BASE_LT:   raw = sg ^ ov;
            BASE_LE:   raw = (sg ^ ov) | zr;
            default:   raw = 1'b0;
        endcase

        if (cond_i == CC_CNT_ZERO) begin
            take_o = cnt_zero_i;
        end else if (cond_i[COND_W-1]) begin
            take_o = 1'b0;
        end else begin
            take_o = raw ^ inv;
        end
    end

endmodule

// File: rtl/psw_cond_unit.sv
module psw_cond_unit
    import psw_pkg::*;
#(
    parameter int                 DATA_W   = 16,
    parameter logic [FLAGS_W-1:0] RSVD_VAL = 16'hF002
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [DATA_W-1:0]   res_i,
    input  logic                carry_i,
    input  logic                aux_i,
    input  logic                ovf_i,
    input  logic                wide_i,
    input  logic [N_UPD-1:0]    upd_en_i,
    input  logic [N_CTL-1:0]    ctl_set_i,
    input  logic [N_CTL-1:0]    ctl_clr_i,
    input  logic                load_i,
    input  logic [FLAGS_W-1:0]  load_val_i,
    input  logic [COND_W-1:0]   cond_i,
    input  logic                cnt_zero_i,
    output logic [FLAGS_W-1:0]  flags_o,
    output logic                take_o
);
    localparam logic [FLAGS_W-1:0] RSVD_FIX = RSVD_VAL & ~DEF_MASK;

    psw_state_t state_d, state_q;

    logic             zero_w, sign_w, par_w;
    logic [N_UPD-1:0] cand;
    logic [N_CTL-1:0] ctl_cur, ctl_nxt;

    psw_result_eval #(.DATA_W(DATA_W)) result_i (
        .res_i  (res_i),
        .wide_i (wide_i),
        .zero_o (zero_w),
        .sign_o (sign_w),
        .par_o  (par_w)
    );

    // Candidate vector in enable-bit order
    assign cand = {ovf_i, sign_w, zero_w, aux_i, par_w, carry_i};

    for (genvar g = 0; g < N_CTL; g++) begin : g_ctl_tap
        assign ctl_cur[g] = state_q.flags[ctl_pos(g)];
    end

    psw_ctl_next #(.NUM(N_CTL)) ctl_i (
        .cur_i (ctl_cur),
        .set_i (ctl_set_i),
        .clr_i (ctl_clr_i),
        .nxt_o (ctl_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.flags = load_val_i;
        end else begin
            for (int i = 0; i < N_UPD; i++) begin
                if (upd_en_i[i]) begin
                    state_d.flags[upd_pos(i)] = cand[i];
                end
            end
            for (int j = 0; j < N_CTL; j++) begin
                state_d.flags[ctl_pos(j)] = ctl_nxt[j];
            end
        end
        state_d.flags = (state_d.flags & DEF_MASK) | RSVD_FIX;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.flags <= RSVD_FIX;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;

    psw_branch_eval branch_i (
        .flags_i    (state_q.flags),
        .cond_i     (cond_i),
        .cnt_zero_i (cnt_zero_i),
        .take_o     (take_o)
    );

endmodule

// File: rtl/psw_cond_unit_chk.sv
module psw_cond_unit_chk
    import psw_pkg::*;
#(
    parameter int                 DATA_W   = 16,
    parameter logic [FLAGS_W-1:0] RSVD_VAL = 16'hF002
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [DATA_W-1:0]  res_i,
    input  logic               carry_i,
    input  logic               wide_i,
    input  logic [N_UPD-1:0]   upd_en_i,
    input  logic [N_CTL-1:0]   ctl_set_i,
    input  logic [N_CTL-1:0]   ctl_clr_i,
    input  logic               load_i,
    input  logic [FLAGS_W-1:0] load_val_i,
    input  logic [COND_W-1:0]  cond_i,
    input  logic               cnt_zero_i,
    input  logic [FLAGS_W-1:0] flags_o,
    input  logic               take_o
);
    p_rsvd_const_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_o & ~DEF_MASK) == (RSVD_VAL & ~DEF_MASK));

    p_load_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> flags_o == (($past(load_val_i) & DEF_MASK) | (RSVD_VAL & ~DEF_MASK)));

    p_ctl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && ctl_set_i == '0 && ctl_clr_i == '0) |=> $stable(flags_o & CTL_MASK));

    p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && upd_en_i == '0) |=> $stable(flags_o & COND_MASK));

    p_carry_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && upd_en_i[0]) |=> flags_o[POS_CARRY] == $past(carry_i));

    p_sign_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && upd_en_i[4]) |=>
            flags_o[POS_SIGN] == $past(wide_i ? res_i[DATA_W-1] : res_i[BYTE_W-1]));

    p_cnt_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i == CC_CNT_ZERO) |-> take_o == cnt_zero_i);

    p_unused_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cond_i > CC_CNT_ZERO) |-> !take_o);

endmodule

bind psw_cond_unit psw_cond_unit_chk #(.DATA_W(DATA_W), .RSVD_VAL(RSVD_VAL)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .res_i      (res_i),
    .carry_i    (carry_i),
    .wide_i     (wide_i),
    .upd_en_i   (upd_en_i),
    .ctl_set_i  (ctl_set_i),
    .ctl_clr_i  (ctl_clr_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .cond_i     (cond_i),
    .cnt_zero_i (cnt_zero_i),
    .flags_o    (flags_o),
    .take_o     (take_o)
);

// File: tb/psw_cond_unit_tb_top.sv
module psw_cond_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] res_i = '0;
    logic        carry_i = 1'b0, aux_i = 1'b0, ovf_i = 1'b0, wide_i = 1'b0;
    logic [5:0]  upd_en_i = '0;
    logic [2:0]  ctl_set_i = '0, ctl_clr_i = '0;
    logic        load_i = 1'b0;
    logic [15:0] load_val_i = '0;
    logic [4:0]  cond_i = '0;
    logic        cnt_zero_i = 1'b0;
    logic [15:0] flags_o;
    logic        take_o;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] exp_flags;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    psw_cond_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .res_i(res_i), .carry_i(carry_i),
        .aux_i(aux_i), .ovf_i(ovf_i), .wide_i(wide_i), .upd_en_i(upd_en_i),
        .ctl_set_i(ctl_set_i), .ctl_clr_i(ctl_clr_i), .load_i(load_i),
        .load_val_i(load_val_i), .cond_i(cond_i), .cnt_zero_i(cnt_zero_i),
        .flags_o(flags_o), .take_o(take_o)
    );

    function automatic logic [15:0] model_next(input logic [15:0] f);
        logic [15:0] n;
        int ones;
        logic zr, sg;
        if (load_i) return (load_val_i & 16'h0FD5) | 16'hF002;
        n = f;
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(res_i[k]);
        zr = wide_i ? (res_i == 16'h0) : (res_i[7:0] == 8'h0);
        sg = wide_i ? res_i[15] : res_i[7];
        if (upd_en_i[0]) n[0]  = carry_i;
        if (upd_en_i[1]) n[2]  = (ones % 2 == 0);
        if (upd_en_i[2]) n[4]  = aux_i;
        if (upd_en_i[3]) n[6]  = zr;
        if (upd_en_i[4]) n[7]  = sg;
        if (upd_en_i[5]) n[11] = ovf_i;
        for (int c = 0; c < 3; c++) begin
            if (ctl_set_i[c]) n[8+c] = 1'b1;
            else if (ctl_clr_i[c]) n[8+c] = 1'b0;
        end
        return n;
    endfunction

    function automatic logic pred(input logic [15:0] f, input logic [4:0] cc, input logic cz);
        logic c, p, z, s, o;
        c = f[0]; p = f[2]; z = f[6]; s = f[7]; o = f[11];
        case (cc)
            5'd0:  return o;
            5'd1:  return !o;
            5'd2:  return c;
            5'd3:  return !c;
            5'd4:  return z;
            5'd5:  return !z;
            5'd6:  return c || z;
            5'd7:  return !(c || z);
            5'd8:  return s;
            5'd9:  return !s;
            5'd10: return p;
            5'd11: return !p;
            5'd12: return s != o;
            5'd13: return s == o;
            5'd14: return (s != o) || z;
            5'd15: return !((s != o) || z);
            5'd16: return cz;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Called right after a negedge with inputs already set
    task automatic step(input string ftag, input string ttag);
        logic [15:0] nxt;
        #1;
        chk1(ttag, take_o, pred(exp_flags, cond_i, cnt_zero_i));
        nxt = model_next(exp_flags);
        @(posedge clk_i);
        @(negedge clk_i);
        exp_flags = nxt;
        chk16(ftag, flags_o, exp_flags);
    endtask

    task automatic idle_inputs();
        upd_en_i = '0; ctl_set_i = '0; ctl_clr_i = '0; load_i = 1'b0;
        res_i = '0; carry_i = 0; aux_i = 0; ovf_i = 0; wide_i = 0;
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        exp_flags = 16'hF002;
        chk16("R1 reset value", flags_o, 16'hF002);
        cond_i = 5'd5; #1;
        chk1("R11 not-zero after reset", take_o, 1'b1);

        // R8/R2: load all ones, reserved bits forced
        load_i = 1; load_val_i = 16'hFFFF; upd_en_i = 6'h3F; ctl_clr_i = 3'b111;
        step("R8 load overrides", "R13 take");
        chk16("R2 reserved after load", flags_o, 16'hFFD7);
        idle_inputs();
        load_i = 1; load_val_i = 16'h0000;
        step("R8 load zero", "R13 take");
        chk16("R2 reserved after zero load", flags_o, 16'hF002);
        idle_inputs();

        // R4/R5: byte result with nonzero high byte
        upd_en_i = 6'h3F; wide_i = 0; res_i = 16'h0100;
        step("R4 byte zero", "R13 take");
        chk1("R4 byte zero flag", flags_o[6], 1'b1);
        chk1("R5 parity of zero byte", flags_o[2], 1'b1);
        wide_i = 1; res_i = 16'h8000; carry_i = 1; ovf_i = 1;
        step("R4 word sign", "R13 take");
        chk1("R4 word zero clear", flags_o[6], 1'b0);
        chk1("R4 word sign set", flags_o[7], 1'b1);
        chk1("R3 carry captured", flags_o[0], 1'b1);
        wide_i = 0; res_i = 16'h0007; upd_en_i = 6'b000010;
        step("R5 odd parity", "R13 take");
        chk1("R5 odd parity clear", flags_o[2], 1'b0);
        chk1("R6 masked sign kept", flags_o[7], 1'b1);

        // R9/R10: sign=1, overflow=1, carry=1, zero=0
        idle_inputs();
        for (int cc = 0; cc < 32; cc++) begin
            cond_i = cc[4:0]; cnt_zero_i = cc[0]; #1;
            chk1("R9 R10 R11 R12 predicate table", take_o, pred(exp_flags, cond_i, cnt_zero_i));
        end
        cond_i = 5'd12; #1; chk1("R9 less with sign==ovf", take_o, 1'b0);
        cond_i = 5'd6;  #1; chk1("R10 below-or-equal", take_o, 1'b1);
        cond_i = 5'd16; cnt_zero_i = 1; #1; chk1("R12 counter zero", take_o, 1'b1);
        cond_i = 5'd17; #1; chk1("R12 unused code", take_o, 1'b0);

        // R7: set wins over clear
        ctl_set_i = 3'b101; ctl_clr_i = 3'b111;
        step("R7 set priority", "R13 take");
        chk16("R7 control bits", flags_o & 16'h0700, 16'h0500);
        idle_inputs();
        res_i = 16'hFFFF; carry_i = 1; aux_i = 1;
        step("R6 nothing enabled", "R13 take");
        chk16("R7 control hold", flags_o & 16'h0700, 16'h0500);

        // Random phase
        for (int it = 0; it < 3000; it++) begin
            res_i      = ($urandom % 8 == 0) ? 16'h0000 : 16'($urandom);
            if ($urandom % 8 == 1) res_i[7:0] = 8'h00;
            carry_i    = 1'($urandom);
            aux_i      = 1'($urandom);
            ovf_i      = 1'($urandom);
            wide_i     = 1'($urandom);
            upd_en_i   = 6'($urandom);
            ctl_set_i  = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            ctl_clr_i  = ($urandom % 4 == 0) ? 3'($urandom) : 3'b000;
            load_i     = ($urandom % 16 == 0);
            load_val_i = 16'($urandom);
            cond_i     = 5'($urandom);
            cnt_zero_i = 1'($urandom);
            step("R3 R4 R5 R6 R7 R8 random flags", "R9 R10 R11 R12 R13 random predicate");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule